// File: doc/BRIEF.md
# 12-bit Accumulator Processor Core

This block is a small multi-cycle processor. It works on 12-bit words and has one accumulator and a one-bit link. It runs the six memory-reference operations: bitwise AND, two's-complement add, increment-and-skip-if-zero, deposit-and-clear, subroutine call and jump. Each of these can address a word on page zero or on the page of the instruction, either directly or through a pointer word. One operate word stops the core. Every other operate word, and every input/output transfer word, passes through as a no-op.

The core drives a synchronous 4096 x 12 memory that sits outside it. The core presents an address, and the memory returns the read word on the following clock. A write is one cycle with the write strobe high, the address and the write data all valid together. This memory port has a fixed latency and is always ready, so it has no valid/ready handshake and no back-pressure. The program counter, accumulator, link and halted flag are plain status outputs. While the core is halted, a `start` pulse resumes it.

Each instruction passes through these states in order: a fetch, then an optional pointer read, then an execute step, then an operand read or a write-back where the operation needs one. Every read spends one extra cycle waiting for the memory to answer.

Top module: `acc12_core`

## Requirements
- R1: When `rst` is high at a rising clock edge, the core clears the program counter, accumulator, link and halted flag. Fetching then starts at address 0.
- R2: The top three instruction bits select the operation: 0 AND, 1 add, 2 increment-skip, 3 deposit, 4 call, 5 jump, 6 I/O, 7 operate. Bit 7 clear gives the address {00000, bits 6..0}. Bit 7 set gives the address {upper five bits of the instruction's own address, bits 6..0}. The program counter advances by one, modulo 4096, as each instruction word is read.
- R3: When bit 8 is set on operations 0 to 5, the core reads the word at the computed address, and that word becomes the effective address.
- R4: AND replaces the accumulator with the bitwise AND of the accumulator and the operand. Add sums the operand into the accumulator modulo 4096, and a carry out of bit 11 inverts the link.
- R5: Increment-skip writes the operand plus one, modulo 4096, back to the same address. When that result is zero, the following instruction is skipped.
- R6: Deposit writes the accumulator to the effective address and then clears the accumulator.
- R7: Call writes the address of the word after the call to the effective address. Execution then continues at the effective address plus one.
- R8: Jump loads the effective address into the program counter.
- R9: The word 7402 (octal) sets `halted` and leaves the program counter on the word after it. While `halted` is high and `start` is low, the program counter, accumulator and link hold their values. A `start` pulse clears `halted`, and execution resumes at that next word.
- R10: I/O words and every operate word other than 7402 change neither the accumulator nor the link, and cause no memory write. Bit 8 of these words does not trigger a pointer read.
- R11: The core writes memory only for deposit, call and increment-skip. Each write lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Resume from halt |
| mem_addr | output | 12 | Memory address for a read or a write |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle per write |
| mem_rdata | input | 12 | Read word, valid one cycle after its address |
| pc | output | 12 | Program counter |
| acc | output | 12 | Accumulator |
| link | output | 1 | Link bit |
| halted | output | 1 | High while the core is stopped |

## Verification
The corner that is hardest to reach from the ports is the increment-skip whose result wraps to zero. A pointer started at a low address only gets there after thousands of loop passes. The stimulus therefore runs a complete fill loop: through an incrementing pointer, it deposits 5252 into every word from 0010 to 7777, until the pointer wraps, the skip fires and the halt word stops the core. A second program reaches the other paths: a carry into the link, calls through the current page, returns through a pointer, no-op words that have bit 8 set, and a resume from halt.

// File: rtl/acc12_pkg.sv
package acc12_pkg;
  typedef enum logic [3:0] {
    ST_FETCH, ST_FWAIT, ST_IND, ST_IWAIT, ST_EXEC,
    ST_RD, ST_RWAIT, ST_WR, ST_HALT
  } st_t;

  typedef enum logic [2:0] {
    OP_AND = 3'd0, OP_TAD = 3'd1, OP_ISZ = 3'd2, OP_DCA = 3'd3,
    OP_JMS = 3'd4, OP_JMP = 3'd5, OP_IOT = 3'd6, OP_OPR = 3'd7
  } op_t;
endpackage

// File: rtl/acc12_ea.sv
// Direct effective address: page zero, or the page of the instruction.
module acc12_ea #(
  parameter int W     = 12,
  parameter int OFF_W = 7
) (
  input  logic [W-1:0] instr,
  input  logic [W-1:0] ipc,
  output logic [W-1:0] ea
);
  localparam int PG_W = W - OFF_W;

  always_comb begin
    if (instr[OFF_W]) ea = {ipc[W-1:OFF_W], instr[OFF_W-1:0]};
    else              ea = {{PG_W{1'b0}}, instr[OFF_W-1:0]};
  end
endmodule

// File: rtl/acc12_alu.sv
// Accumulator update for AND and add, plus the increment used by ISZ.
module acc12_alu
  import acc12_pkg::*;
#(
  parameter int W = 12
) (
  input  op_t          op,
  input  logic [W-1:0] ac,
  input  logic         lk,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] ac_nx,
  output logic         lk_nx,
  output logic [W-1:0] inc,
  output logic         inc_zero
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W:0] sum;

  always_comb begin
    sum      = {1'b0, ac} + {1'b0, opnd};
    inc      = opnd + ONE;
    inc_zero = (inc == '0);
    ac_nx    = ac;
    lk_nx    = lk;
    case (op)
      OP_AND: ac_nx = ac & opnd;
      OP_TAD: begin
        ac_nx = sum[W-1:0];
        lk_nx = lk ^ sum[W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc12_core.sv
module acc12_core
  import acc12_pkg::*;
#(
  parameter int          W         = 12,
  parameter int          OFF_W     = 7,
  parameter logic [11:0] HALT_WORD = 12'o7402
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] acc,
  output logic         link,
  output logic         halted
);
  localparam int           OP_LSB  = W - 3;
  localparam int           IND_BIT = OFF_W + 1;
  localparam logic [W-1:0] ONE     = W'(1);

  st_t          st_q;
  op_t          op_q;
  logic [W-1:0] pc_q, ac_q, ea_q, wd_q;
  logic         lk_q, hlt_q;

  op_t          fw_op;
  logic [W-1:0] ea_dir;
  logic [W-1:0] alu_ac, alu_inc;
  logic         alu_lk, alu_zero;

  assign fw_op = op_t'(mem_rdata[W-1:OP_LSB]);

  // The page comes from pc_q, which still holds the instruction's address
  // during ST_FWAIT.
  acc12_ea #(.W(W), .OFF_W(OFF_W)) u_ea (
    .instr (mem_rdata),
    .ipc   (pc_q),
    .ea    (ea_dir)
  );

  acc12_alu #(.W(W)) u_alu (
    .op       (op_q),
    .ac       (ac_q),
    .lk       (lk_q),
    .opnd     (mem_rdata),
    .ac_nx    (alu_ac),
    .lk_nx    (alu_lk),
    .inc      (alu_inc),
    .inc_zero (alu_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_FETCH;
      op_q  <= OP_AND;
      pc_q  <= '0;
      ac_q  <= '0;
      ea_q  <= '0;
      wd_q  <= '0;
      lk_q  <= 1'b0;
      hlt_q <= 1'b0;
    end else begin
      case (st_q)
        ST_FETCH: st_q <= ST_FWAIT;
        ST_FWAIT: begin
          pc_q <= pc_q + ONE;
          op_q <= fw_op;
          ea_q <= ea_dir;
          if (fw_op == OP_OPR) begin
            if (mem_rdata == HALT_WORD) begin
              hlt_q <= 1'b1;
              st_q  <= ST_HALT;
            end else begin
              st_q <= ST_FETCH;
            end
          end else if (fw_op == OP_IOT) begin
            st_q <= ST_FETCH;
          end else if (mem_rdata[IND_BIT]) begin
            st_q <= ST_IND;
          end else begin
            st_q <= ST_EXEC;
          end
        end
        ST_IND:   st_q <= ST_IWAIT;
        ST_IWAIT: begin
          ea_q <= mem_rdata;
          st_q <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op_q)
            OP_DCA: begin
              wd_q <= ac_q;
              ac_q <= '0;
              st_q <= ST_WR;
            end
            OP_JMS: begin
              wd_q <= pc_q;
              pc_q <= ea_q + ONE;
              st_q <= ST_WR;
            end
            OP_JMP: begin
              pc_q <= ea_q;
              st_q <= ST_FETCH;
            end
            default: st_q <= ST_RD;
          endcase
        end
        ST_RD:    st_q <= ST_RWAIT;
        ST_RWAIT: begin
          if (op_q == OP_ISZ) begin
            wd_q <= alu_inc;
            if (alu_zero) pc_q <= pc_q + ONE;
            st_q <= ST_WR;
          end else begin
            ac_q <= alu_ac;
            lk_q <= alu_lk;
            st_q <= ST_FETCH;
          end
        end
        ST_WR:    st_q <= ST_FETCH;
        ST_HALT: begin
          if (start) begin
            hlt_q <= 1'b0;
            st_q  <= ST_FETCH;
          end
        end
        default:  st_q <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    mem_addr  = (st_q == ST_FETCH) ? pc_q : ea_q;
    mem_we    = (st_q == ST_WR);
    mem_wdata = wd_q;
  end

  assign pc     = pc_q;
  assign acc    = ac_q;
  assign link   = lk_q;
  assign halted = hlt_q;
endmodule

// File: rtl/acc12_chk.sv
module acc12_chk
  import acc12_pkg::*;
#(
  parameter int          W         = 12,
  parameter logic [11:0] HALT_WORD = 12'o7402
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input st_t          state,
  input op_t          op,
  input logic [W-1:0] ea,
  input logic [W-1:0] mem_rdata,
  input logic [W-1:0] mem_wdata,
  input logic         mem_we,
  input logic [W-1:0] pc,
  input logic [W-1:0] acc,
  input logic         link,
  input logic         halted
);
  localparam logic [W-1:0] ONE = W'(1);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && acc == '0 && !link && !halted));

  a_r2_fetch_advance: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FWAIT) |=> (pc == $past(pc) + ONE));

  a_r4_add_wraps: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RWAIT && op == OP_TAD) |=> (acc == $past(acc) + $past(mem_rdata)));

  a_r5_skip_on_zero: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RWAIT && op == OP_ISZ && mem_rdata == {W{1'b1}})
      |=> (pc == $past(pc) + ONE && mem_wdata == '0));

  a_r6_deposit_clear: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op == OP_DCA) |=> (acc == '0 && mem_we && mem_wdata == $past(acc)));

  a_r7_call_link: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op == OP_JMS)
      |=> (mem_we && mem_wdata == $past(pc) && pc == $past(ea) + ONE));

  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op == OP_JMP) |=> (pc == $past(ea)));

  a_r9_halt_word: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FWAIT && mem_rdata == HALT_WORD) |=> halted);

  a_r9_hold_while_halted: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> (halted && $stable(pc) && $stable(acc) && $stable(link)));

  a_r11_single_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind acc12_core acc12_chk #(.W(W), .HALT_WORD(HALT_WORD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .state     (st_q),
  .op        (op_q),
  .ea        (ea_q),
  .mem_rdata (mem_rdata),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .pc        (pc),
  .acc       (acc),
  .link      (link),
  .halted    (halted)
);

// File: tb/tb_acc12_core.sv
module tb_acc12_core;
  localparam int W     = 12;
  localparam int DEPTH = 4096;

  logic         clk = 1'b0;
  logic         rst, start;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata, pc, acc;
  logic         mem_we, link, halted;

  always #5 clk = ~clk;

  acc12_core dut (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .pc(pc), .acc(acc), .link(link), .halted(halted)
  );

  // Synchronous memory seen by the core
  logic [W-1:0] mem [DEPTH];
  always @(posedge clk) begin
    if (mem_we === 1'b1) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // Reference model state and scoreboard
  logic [W-1:0] mm [DEPTH];
  logic [W-1:0] m_pc, m_ac;
  logic         m_lk;
  logic [W-1:0] q_a[$];
  logic [W-1:0] q_d[$];
  string        q_t[$];
  int n_run = 0, n_fail = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %o expected %o", tag, what, act, exp);
    end
  endtask

  task automatic put(input int a, input int d);
    mem[a] = W'(d);
    mm[a]  = W'(d);
  endtask

  task automatic clear_all();
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = '0;
      mm[i]  = '0;
    end
    q_a.delete(); q_d.delete(); q_t.delete();
    m_pc = '0; m_ac = '0; m_lk = 1'b0;
  endtask

  // Driver: runs the reference model up to a halt word and queues every write
  task automatic model_run();
    logic [W-1:0] ins, ea, t;
    logic [2:0]   op;
    logic [W:0]   s;
    bit           done = 0;
    while (!done) begin
      ins = mm[m_pc];
      op  = ins[11:9];
      ea  = ins[7] ? {m_pc[11:7], ins[6:0]} : {5'b0, ins[6:0]};
      m_pc = m_pc + 1'b1;
      if (op < 3'd6 && ins[8]) ea = mm[ea];
      case (op)
        3'd0: m_ac = m_ac & mm[ea];
        3'd1: begin
          s = {1'b0, m_ac} + {1'b0, mm[ea]};
          m_ac = s[W-1:0];
          if (s[W]) m_lk = ~m_lk;
        end
        3'd2: begin
          t = mm[ea] + 1'b1;
          mm[ea] = t;
          q_a.push_back(ea); q_d.push_back(t); q_t.push_back("R5");
          if (t == '0) m_pc = m_pc + 1'b1;
        end
        3'd3: begin
          mm[ea] = m_ac;
          q_a.push_back(ea); q_d.push_back(m_ac); q_t.push_back("R6");
          m_ac = '0;
        end
        3'd4: begin
          mm[ea] = m_pc;
          q_a.push_back(ea); q_d.push_back(m_pc); q_t.push_back("R7");
          m_pc = ea + 1'b1;
        end
        3'd5: m_pc = ea;
        3'd7: if (ins == 12'o7402) done = 1;
        default: ;
      endcase
    end
  endtask

  // Monitor: compares each write strobe against the queued expectation
  always @(negedge clk) begin : monitor
    logic [W-1:0] ea_e, d_e;
    string tg;
    if (rst === 1'b0 && mem_we === 1'b1) begin
      n_run++;
      if (q_a.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected write: actual %o<-%o expected none", mem_addr, mem_wdata);
      end else begin
        ea_e = q_a.pop_front();
        d_e  = q_d.pop_front();
        tg   = q_t.pop_front();
        if (mem_addr !== ea_e || mem_wdata !== d_e) begin
          n_fail++;
          $display("FAIL %s write: actual %o<-%o expected %o<-%o",
                   tg, mem_addr, mem_wdata, ea_e, d_e);
        end
      end
    end
  end

  task automatic wait_halt(input int limit);
    int c = 0;
    while (halted !== 1'b1 && c < limit) begin
      @(negedge clk);
      c++;
    end
    n_run++;
    if (c >= limit) begin
      n_fail++;
      $display("FAIL R9 halt not reached: actual %0d cycles expected fewer than %0d", c, limit);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin : main
    int cnt;
    rst = 1'b1; start = 1'b0;
    clear_all();
    // Program 1: fill 0010..7777 with 5252 through an incrementing pointer
    put(0, 12'o1007); put(1, 12'o3406); put(2, 12'o2006); put(3, 12'o5000);
    put(4, 12'o7402); put(6, 12'o0010); put(7, 12'o5252);
    repeat (3) @(negedge clk);
    check("R1", "pc", pc, 0);
    check("R1", "acc", acc, 0);
    check("R1", "link", link, 0);
    check("R1", "halted", halted, 0);
    model_run();
    rst = 1'b0;
    wait_halt(120000);
    check("R9", "halted", halted, 1);
    check("R9", "pc after halt", pc, 5);
    check("R6", "acc", acc, 0);
    check("R5", "pointer wrapped", mem[6], 0);
    cnt = 0;
    for (int a = 8; a < DEPTH; a++) if (mem[a] == 12'o5252) cnt++;
    check("R3", "filled words", cnt, DEPTH - 8);
    check("R3", "first filled", mem[8], 12'o5252);
    check("R3", "last filled", mem[DEPTH-1], 12'o5252);
    check("R11", "pending writes", q_a.size(), 0);
    repeat (5) @(negedge clk);
    check("R9", "pc held", pc, 5);
    check("R9", "still halted", halted, 1);

    // Program 2: link carry, AND, no-ops, call/return, skip, resume
    rst = 1'b1;
    repeat (2) @(negedge clk);
    clear_all();
    put(0, 12'o5402); put(2, 12'o0200); put(3, 12'o0270);
    put(12'o0200, 12'o1250); put(12'o0201, 12'o1251); put(12'o0202, 12'o1253);
    put(12'o0203, 12'o0252); put(12'o0204, 12'o6401); put(12'o0205, 12'o7401);
    put(12'o0206, 12'o4260); put(12'o0207, 12'o2264); put(12'o0210, 12'o7402);
    put(12'o0211, 12'o2265); put(12'o0212, 12'o7402); put(12'o0213, 12'o1266);
    put(12'o0214, 12'o3403); put(12'o0215, 12'o7402);
    put(12'o0250, 12'o7777); put(12'o0251, 12'o0002); put(12'o0252, 12'o0707);
    put(12'o0253, 12'o6363); put(12'o0261, 12'o3257); put(12'o0262, 12'o5660);
    put(12'o0264, 12'o0005); put(12'o0265, 12'o7777); put(12'o0266, 12'o0001);
    model_run();
    rst = 1'b0;
    wait_halt(2000);
    check("R9", "pc at first halt", pc, 12'o0211);
    check("R8", "pc vs reference", pc, m_pc);
    check("R4", "link after carry", link, 1);
    check("R4", "link vs reference", link, m_lk);
    check("R6", "acc", acc, 0);
    check("R10", "AND result kept across no-ops", mem[12'o0257], 12'o0304);
    check("R7", "return address", mem[12'o0260], 12'o0207);
    check("R5", "no-skip increment", mem[12'o0264], 12'o0006);
    check("R11", "pending writes", q_a.size(), 0);

    model_run();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9", "resumed", halted, 0);
    wait_halt(2000);
    check("R5", "skip past halt", pc, 12'o0216);
    check("R2", "pc vs reference", pc, m_pc);
    check("R5", "wrapped operand", mem[12'o0265], 0);
    check("R3", "page-zero pointer target", mem[12'o0270], 1);
    check("R4", "link held", link, 1);
    check("R6", "acc", acc, 0);
    check("R11", "pending writes", q_a.size(), 0);

    summary();
    $finish;
  end
endmodule